// File: doc/BRIEF.md
# Host-to-PCI Sequential Write Burst Combiner

This block sits on the host side of a host-to-PCI bridge. It takes posted CPU memory writes (address, data, byte enables), stores them in a small first-in first-out buffer, and releases the host at once. The host never waits for the PCI transaction to finish. A PCI master state machine empties the buffer. Writes that arrive back to back with addresses one word apart go out as a single PCI burst, with one data phase on every clock and no master wait states. A write that breaks the address sequence, or a buffer that runs dry, closes the burst. The next write then gets a fresh address phase.

The PCI side runs on the same clock as the bridge. For readability every PCI control signal here is active high: `pci_frame`, `pci_irdy` and `pci_trdy` are 1 when asserted. Byte enables are also active high, so 1 means the byte lane is written.

The master state machine has three states:
- `M_IDLE`: the bus is released.
- `M_ADDR`: the single address phase.
- `M_DATA`: the data phases.

It has four transitions:
- *start*: `M_IDLE`→`M_ADDR`, when the buffer holds an entry.
- *launch*: `M_ADDR`→`M_DATA`, always.
- *stream*: `M_DATA`→`M_DATA`, on a stall, or on a transfer with frame still asserted.
- *finish*: `M_DATA`→`M_IDLE`, on the transfer made with frame deasserted.

Top module: `pci_wr_combiner`

## Requirements
- R1: `host_ready` is 1 whenever the buffer holds fewer than DEPTH entries. A write is accepted on any clock where `host_valid` and `host_ready` are both 1, whatever the PCI side is doing.
- R2: With DEPTH entries held, `host_ready` is 0. It returns to 1 the cycle after an entry drains.
- R3: A burst starts with one address phase. In it, `pci_frame`=1, `pci_irdy`=0, `pci_ad` carries the address of the oldest entry, and `pci_cbe`=4'b0111 (the memory write command). The address phase occurs the cycle after the machine is idle with a non-empty buffer.
- R4: In every data phase, `pci_ad` carries the oldest entry's data and `pci_cbe` carries that write's byte enables unchanged. The entry is consumed on a clock where `pci_irdy` and `pci_trdy` are both 1.
- R5: `pci_irdy` is 1 on every cycle from the cycle after the address phase up to and including the final transfer (zero master wait states).
- R6: A buffered entry whose address equals the address of the write accepted just before it plus 4 continues the current burst. This holds when that entry is already buffered while the preceding data phase is pending.
- R7: `pci_frame` is 0 during the final data phase of a burst. Once it falls inside a burst, it stays 0 until that burst's final transfer.
- R8: A write whose address is not the previous accepted write's address plus 4 is never joined to the burst ahead of it. It gets its own address phase.
- R9: The cycle after a final transfer has `pci_frame`=0 and `pci_irdy`=0.
- R10: While `pci_irdy`=1 and `pci_trdy`=0, the next cycle keeps `pci_irdy`=1 with `pci_ad` and `pci_cbe` unchanged.
- R11: During reset, `pci_frame`=0, `pci_irdy`=0 and `host_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock, shared with PCI |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host write request |
| host_addr | input | ADW | Write address (byte address, word aligned) |
| host_data | input | ADW | Write data |
| host_be | input | ADW/8 | Byte enables, 1 = lane written |
| host_ready | output | 1 | Buffer can accept a write |
| pci_frame | output | 1 | Transaction framing, active high |
| pci_irdy | output | 1 | Master data ready, active high |
| pci_trdy | input | 1 | Target ready, active high |
| pci_ad | output | ADW | Address during address phase, data during data phases |
| pci_cbe | output | ADW/8 | Command during address phase, byte enables during data phases |

## Verification
The two functions that can fall in the same cycle are the burst-length decision on the pending data phase and the acceptance of a new host write that would extend the burst. The bench holds `pci_trdy` low while a lone write sits in its data phase with frame already down. It then posts the sequential follower, which must open a second burst rather than revive frame. Randomly stalled targets mixed with sequential and non-sequential streams also push and pop in the same cycle. The cycle-by-cycle queue model decides every expected frame, ready and data value.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_ADDR = 2'd1,
        M_DATA = 2'd2
    } mst_state_t;

    localparam logic [3:0] CMD_MEM_WRITE = 4'b0111;

endpackage

// File: rtl/pcw_post_fifo.sv
module pcw_post_fifo #(
    parameter int ADW   = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = ADW / 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           push,
    input  logic [ADW-1:0] push_addr,
    input  logic [ADW-1:0] push_data,
    input  logic [BEW-1:0] push_be,
    input  logic           pop,
    output logic [CW-1:0]  count,
    output logic           full,
    output logic           empty,
    output logic [ADW-1:0] head_addr,
    output logic [ADW-1:0] head_data,
    output logic [BEW-1:0] head_be,
    output logic           more_seq
);

    localparam logic [PW-1:0]  LAST_SLOT = PW'(DEPTH - 1);
    localparam logic [ADW-1:0] STEP      = ADW'(BEW);

    logic [ADW-1:0] mem_addr [DEPTH];
    logic [ADW-1:0] mem_data [DEPTH];
    logic [BEW-1:0] mem_be   [DEPTH];
    logic [DEPTH-1:0] mem_seq;

    logic [PW-1:0]  wr_ptr, rd_ptr, nx_ptr;
    logic [ADW-1:0] prev_addr;
    logic           prev_vld;
    logic           seq_in;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    // sequence flag is computed once, when the write is accepted
    assign seq_in = prev_vld && (push_addr == prev_addr + STEP);
    assign nx_ptr = bump(rd_ptr);

    always_ff @(posedge clk) begin
        if (push) begin
            mem_addr[wr_ptr] <= push_addr;
            mem_data[wr_ptr] <= push_data;
            mem_be[wr_ptr]   <= push_be;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            prev_addr <= '0;
            prev_vld  <= 1'b0;
            mem_seq   <= '0;
        end else begin
            if (push) begin
                wr_ptr          <= bump(wr_ptr);
                mem_seq[wr_ptr] <= seq_in;
                prev_addr       <= push_addr;
                prev_vld        <= 1'b1;
            end
            if (pop) begin
                rd_ptr <= nx_ptr;
            end
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
    assign head_addr = mem_addr[rd_ptr];
    assign head_data = mem_data[rd_ptr];
    assign head_be   = mem_be[rd_ptr];
    assign more_seq  = (count >= CW'(2)) && mem_seq[nx_ptr];

endmodule

// File: rtl/pcw_burst_master.sv
module pcw_burst_master
    import pcw_pkg::*;
#(
    parameter int ADW  = 32,
    localparam int BEW = ADW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           empty,
    input  logic           more_seq,
    input  logic [ADW-1:0] head_addr,
    input  logic [ADW-1:0] head_data,
    input  logic [BEW-1:0] head_be,
    input  logic           pci_trdy,
    output logic           pci_frame,
    output logic           pci_irdy,
    output logic [ADW-1:0] pci_ad,
    output logic [BEW-1:0] pci_cbe,
    output logic           pop
);

    mst_state_t state, state_nx;
    logic       last_q, last_nx;
    logic       xfer;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= M_IDLE;
            last_q <= 1'b0;
        end else begin
            state  <= state_nx;
            last_q <= last_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        last_nx  = 1'b0;
        unique case (state)
            M_IDLE: if (!empty) state_nx = M_ADDR;       // start
            M_ADDR: state_nx = M_DATA;                   // launch
            M_DATA: begin
                if (xfer && !pci_frame) begin
                    state_nx = M_IDLE;                   // finish
                end else begin
                    // stream; remember a dropped frame across a stall
                    last_nx = !pci_frame && !xfer;
                end
            end
            default: state_nx = M_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pci_frame = 1'b0;
        pci_irdy  = 1'b0;
        pci_ad    = '0;
        pci_cbe   = '0;
        unique case (state)
            M_IDLE: ;
            M_ADDR: begin
                pci_frame = 1'b1;
                pci_ad    = head_addr;
                pci_cbe   = CMD_MEM_WRITE;
            end
            M_DATA: begin
                pci_frame = more_seq && !last_q;
                pci_irdy  = 1'b1;
                pci_ad    = head_data;
                pci_cbe   = head_be;
            end
            default: ;
        endcase
    end

    assign xfer = (state == M_DATA) && pci_trdy;
    assign pop  = xfer;

endmodule

// File: rtl/pci_wr_combiner.sv
module pci_wr_combiner #(
    parameter int ADW   = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = ADW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           host_valid,
    input  logic [ADW-1:0] host_addr,
    input  logic [ADW-1:0] host_data,
    input  logic [BEW-1:0] host_be,
    output logic           host_ready,
    output logic           pci_frame,
    output logic           pci_irdy,
    input  logic           pci_trdy,
    output logic [ADW-1:0] pci_ad,
    output logic [BEW-1:0] pci_cbe
);

    logic [CW-1:0]  occ;
    logic           full, empty, more_seq, pop, push;
    logic [ADW-1:0] head_addr, head_data;
    logic [BEW-1:0] head_be;

    assign host_ready = !full;
    assign push       = host_valid && !full;

    pcw_post_fifo #(.ADW(ADW), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (host_addr),
        .push_data (host_data),
        .push_be   (host_be),
        .pop       (pop),
        .count     (occ),
        .full      (full),
        .empty     (empty),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be),
        .more_seq  (more_seq)
    );

    pcw_burst_master #(.ADW(ADW)) u_mst (
        .clk       (clk),
        .rst_n     (rst_n),
        .empty     (empty),
        .more_seq  (more_seq),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be),
        .pci_trdy  (pci_trdy),
        .pci_frame (pci_frame),
        .pci_irdy  (pci_irdy),
        .pci_ad    (pci_ad),
        .pci_cbe   (pci_cbe),
        .pop       (pop)
    );

endmodule

// File: rtl/pcw_checker.sv
module pcw_checker #(
    parameter int ADW   = 32,
    parameter int DEPTH = 4,
    localparam int BEW  = ADW / 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [CW-1:0]  occ,
    input logic           host_ready,
    input logic           pci_frame,
    input logic           pci_irdy,
    input logic           pci_trdy,
    input logic [ADW-1:0] pci_ad,
    input logic [BEW-1:0] pci_cbe
);

    assert_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ < CW'(DEPTH)) |-> host_ready);

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == CW'(DEPTH)) |-> !host_ready);

    assert_addr_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_frame) |-> (!pci_irdy && pci_cbe == 4'b0111));

    assert_data_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_frame && !pci_irdy) |=> pci_irdy);

    assert_no_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_irdy && pci_frame && pci_trdy) |=> pci_irdy);

    assert_frame_falls_in_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_frame) |-> pci_irdy);

    assert_no_reassert_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_irdy && !pci_frame && !pci_trdy) |=> !pci_frame);

    assert_idle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_irdy && pci_trdy && !pci_frame) |=> (!pci_frame && !pci_irdy));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_irdy && !pci_trdy) |=> (pci_irdy && $stable(pci_ad) && $stable(pci_cbe)));

endmodule

bind pci_wr_combiner pcw_checker #(.ADW(ADW), .DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .occ        (occ),
    .host_ready (host_ready),
    .pci_frame  (pci_frame),
    .pci_irdy   (pci_irdy),
    .pci_trdy   (pci_trdy),
    .pci_ad     (pci_ad),
    .pci_cbe    (pci_cbe)
);

// File: tb/tb_pci_wr_combiner.sv
`timescale 1ns/1ps
module tb_pci_wr_combiner;

    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_data = '0;
    logic [3:0]  host_be = '0;
    logic        host_ready;
    logic        pci_frame, pci_irdy;
    logic        pci_trdy = 1'b1;
    logic [31:0] pci_ad;
    logic [3:0]  pci_cbe;

    always #10 clk = ~clk;   // 50 MHz

    pci_wr_combiner #(.ADW(32), .DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .host_valid(host_valid), .host_addr(host_addr),
        .host_data(host_data), .host_be(host_be), .host_ready(host_ready),
        .pci_frame(pci_frame), .pci_irdy(pci_irdy), .pci_trdy(pci_trdy),
        .pci_ad(pci_ad), .pci_cbe(pci_cbe)
    );

    typedef struct {
        logic [31:0] a;
        logic [31:0] d;
        logic [3:0]  be;
        bit          seq;
    } ent_t;

    ent_t        q[$];
    int          ms = 0;        // 0 idle, 1 address, 2 data
    bit          lastf = 0;
    bit          pv = 0;
    logic [31:0] pa = '0;
    bit          prev_frame = 0;
    int          bursts = 0;
    int          xfers = 0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 0;
    bit          rnd_en = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // reference model, compared and advanced once per cycle
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit exp_ready, ef, ei, push, xfer;
            int old_sz, nms;
            exp_ready = q.size() < DEPTH;
            ef = 0; ei = 0;
            chk(host_ready == exp_ready, exp_ready ? "R1" : "R2", "host_ready",
                32'(host_ready), 32'(exp_ready));
            if (ms == 1) begin
                ef = 1;
                chk(pci_ad == q[0].a, "R3", "address", pci_ad, q[0].a);
                chk(pci_cbe == 4'b0111, "R3", "command", 32'(pci_cbe), 32'h7);
            end else if (ms == 2) begin
                ef = (q.size() >= 2) && q[1].seq && !lastf;
                ei = 1;
                chk(pci_ad == q[0].d, "R4", "data", pci_ad, q[0].d);
                chk(pci_cbe == q[0].be, "R4", "byte enables", 32'(pci_cbe), 32'(q[0].be));
            end
            chk(pci_frame == ef, (ms == 2) ? "R7" : "R3", "frame", 32'(pci_frame), 32'(ef));
            chk(pci_irdy == ei, "R5", "irdy", 32'(pci_irdy), 32'(ei));
            if (pci_frame && !prev_frame) bursts++;
            prev_frame = pci_frame;

            push   = host_valid && exp_ready;
            xfer   = (ms == 2) && pci_trdy;
            old_sz = q.size();
            case (ms)
                0:       nms = (old_sz > 0) ? 1 : 0;
                1:       nms = 2;
                default: nms = (xfer && !ef) ? 0 : 2;
            endcase
            lastf = (ms == 2 && nms == 2) ? (lastf || (!ef && !xfer)) : 0;
            ms = nms;
            if (xfer) begin
                void'(q.pop_front());
                xfers++;
            end
            if (push) begin
                ent_t e;
                e.a = host_addr; e.d = host_data; e.be = host_be;
                e.seq = pv && (host_addr == pa + 32'd4);
                q.push_back(e);
                pa = host_addr;
                pv = 1;
            end
        end else if (!rst_n) begin
            prev_frame = 0;
        end
    end

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be);
        bit ok;
        host_valid = 1'b1; host_addr = a; host_data = d; host_be = be;
        do begin
            @(negedge clk); ok = host_ready;
            @(posedge clk); #1;
        end while (!ok);
        host_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic drain();
        int guard = 0;
        while ((q.size() != 0 || ms != 0) && guard < 500) begin
            idle(1); guard++;
        end
        idle(2);
    endtask

    always @(posedge clk) begin
        #1;
        if (rnd_en) pci_trdy = ($urandom % 4) != 0;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(pci_frame == 1'b0, "R11", "reset frame", 32'(pci_frame), 32'h0);
        chk(pci_irdy == 1'b0, "R11", "reset irdy", 32'(pci_irdy), 32'h0);
        chk(host_ready == 1'b1, "R11", "reset ready", 32'(host_ready), 32'h1);
        @(posedge clk); #1; rst_n = 1'b1;
        idle(2);

        // R6: four back-to-back sequential writes make one burst
        bursts = 0; xfers = 0;
        for (int i = 0; i < 4; i++) wr(32'h1000 + 32'(i * 4), 32'hA000_0000 + 32'(i), 4'hF);
        drain();
        chk(bursts == 1, "R6", "burst count", 32'(bursts), 32'd1);
        chk(xfers == 4, "R6", "transfers", 32'(xfers), 32'd4);

        // R8: address gap splits the stream
        bursts = 0;
        wr(32'h2000, 32'h1111_1111, 4'h3);
        wr(32'h2010, 32'h2222_2222, 4'hC);
        wr(32'h2014, 32'h3333_3333, 4'h5);
        drain();
        chk(bursts == 2, "R8", "burst count", 32'(bursts), 32'd2);

        // R7: sequential follower after frame already dropped opens a new burst
        bursts = 0;
        pci_trdy = 1'b0;
        wr(32'h3000, 32'h4444_4444, 4'h1);
        idle(6);
        wr(32'h3004, 32'h5555_5555, 4'h2);
        idle(3);
        pci_trdy = 1'b1;
        drain();
        chk(bursts == 2, "R7", "burst count", 32'(bursts), 32'd2);

        // R2: buffer fills while the target stalls
        pci_trdy = 1'b0;
        for (int i = 0; i < DEPTH; i++) wr(32'h4000 + 32'(i * 4), 32'h6000 + 32'(i), 4'hF);
        @(negedge clk);
        chk(host_ready == 1'b0, "R2", "ready when full", 32'(host_ready), 32'h0);
        @(posedge clk); #1;
        pci_trdy = 1'b1;
        wr(32'h4010, 32'h6004, 4'h9);
        drain();

        // R4 R5 R10: random stalls with mixed sequential and jumping addresses
        rnd_en = 1;
        begin
            logic [31:0] a = 32'h8000;
            for (int i = 0; i < 400; i++) begin
                a = (($urandom % 3) == 0) ? {$urandom} & 32'hFFFF_FFFC : a + 32'd4;
                wr(a, $urandom, 4'($urandom));
                if (($urandom % 5) == 0) idle($urandom % 4);
            end
        end
        rnd_en = 0;
        pci_trdy = 1'b1;
        drain();

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule